// File: doc/BRIEF.md
# Masked Input-Change Interrupt Generator

This block raises an interrupt request whenever a monitored input line no longer matches the level last taken by software. Each line has a stored snapshot. Any input-configured, unmasked line whose synchronised level differs from its snapshot makes the block pull its active-low, open-drain interrupt line low. The output is modelled as a pull-low enable: 1 means drive the wire low, 0 means release it. Software clears the request by reading a bank, which reloads that bank's snapshot. A request also goes away when the line itself returns to its snapshot level. The lines are grouped into banks of eight, and the register interface gives one read strobe per bank. Polarity inversion on the read path plays no part in change detection.

A small sequencer sets the timing. After reset it waits in **SETTLE** until the synchroniser has filled. During that wait every snapshot follows the pin levels and the interrupt is held off. The sequencer then moves to **QUIET** (transition *settle_done*). From QUIET it enters **FLAGGED** when any line is pending (transition *raise*). From FLAGGED it returns to QUIET once nothing is pending (transition *drop*). Reset returns it to SETTLE from any state. The interrupt output is a decode of the FLAGGED state, so it is glitch-free. The mask and configuration vectors come from the register block, which resets all mask bits to 1 and all lines to inputs.

Top module: `irq_change_detect`

## Requirements
- R1: While reset is low, and for the settle period of SYNC_STAGES+1 cycles after it is released, `int_pull_low` is 0.
- R2: Toggle a pin whose `cfg_is_input` bit is 1 and whose `mask_bit` bit is 0. `int_pull_low` becomes 1 three clock edges later: two synchroniser edges and one state edge. It is still 0 after two edges.
- R3: A change on a line whose `mask_bit` bit is 1 leaves `int_pull_low` at 0.
- R4: A change on a line whose `cfg_is_input` bit is 0 (output-configured) leaves `int_pull_low` at 0.
- R5: Pulse `rd_bank_stb[b]` high for one cycle. This reloads the snapshot of lines b*8 to b*8+7 from their synchronised levels. When no other bank is pending, `int_pull_low` returns to 0.
- R6: A read strobe for one bank does not clear a request that is pending in another bank.
- R7: When a pending line returns to its snapshot level before any read, `int_pull_low` returns to 0.
- R8: Changing a mask or configuration bit re-evaluates against the existing snapshot, and `int_pull_low` follows one edge later. Clearing the mask bit of a differing line asserts the interrupt. Setting the mask bit again releases it.
- R9: The snapshot taken during the settle period equals the pin levels that are steady at reset release. Stable pins therefore raise no interrupt after settling, even when they are unmasked and non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_async | input | 40 | Raw pin levels, asynchronous to clk |
| cfg_is_input | input | 40 | Per line: 1 = configured as input |
| mask_bit | input | 40 | Per line: 1 = interrupt masked |
| rd_bank_stb | input | 5 | One-cycle read strobe per bank of 8 lines |
| int_pull_low | output | 1 | 1 = pull the open-drain interrupt wire low |

## Verification
The assertions assume three things about the inputs. Each read strobe is a single-cycle pulse from the register interface. Mask and configuration bits are steady register values. Pin levels are held for several cycles, so the snapshot and the synchronised level can be compared. The stimulus drives every input on the falling edge. It keeps each strobe high for exactly one cycle and leaves each pin change in place for at least three cycles before it checks the output. It also holds the pins steady across reset release, so the settle snapshot is well defined.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_SETTLE  = 2'd0,
        ST_QUIET   = 2'd1,
        ST_FLAGGED = 2'd2
    } irq_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 40,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] sync_b,
    input  logic [BANK_W-1:0] cfg_b,
    input  logic [BANK_W-1:0] mask_b,
    input  logic              load,
    output logic              pend
);
    logic [BANK_W-1:0] snap;
    logic [BANK_W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    snap <= '0;
        else if (load) snap <= sync_b;
    end

    always_comb begin
        diff = (sync_b ^ snap) & cfg_b & ~mask_b;
        pend = |diff;
    end

    // R5: a load captures the synchronised levels of this bank
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (snap == $past(sync_b)));

    // R3: a fully masked bank never reports pending
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_b == '1) |-> !pend);

    // R4: a bank with every line an output never reports pending
    p_outputs_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_b == '0) |-> !pend);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
#(
    parameter int SETTLE_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_any,
    output logic settling,
    output logic flagged
);
    localparam int CW = $clog2(SETTLE_LEN + 1);

    irq_state_e state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SETTLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_SETTLE) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SETTLE:  if (cnt == CW'(SETTLE_LEN - 1)) nxt = ST_QUIET;
            ST_QUIET:   if (pend_any)                   nxt = ST_FLAGGED;
            ST_FLAGGED: if (!pend_any)                  nxt = ST_QUIET;
            default:                                    nxt = ST_SETTLE;
        endcase
    end

    always_comb begin
        settling = (state == ST_SETTLE);
        flagged  = (state == ST_FLAGGED);
    end

    p_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {ST_SETTLE, ST_QUIET, ST_FLAGGED});

    // R1: the settle period never leads straight to a flagged state
    p_settle_no_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |=> (state != ST_FLAGGED));

    // R2: a pending line outside the settle period flags on the next edge
    p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SETTLE && pend_any) |=> (state == ST_FLAGGED));

    // R7: nothing pending releases the flag on the next edge
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLAGGED && !pend_any) |=> (state == ST_QUIET));
endmodule

// File: rtl/irq_change_detect.sv
module irq_change_detect #(
    parameter int NUM_BANKS   = 5,
    parameter int BANK_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_async,
    input  logic [NUM_BANKS*BANK_W-1:0] cfg_is_input,
    input  logic [NUM_BANKS*BANK_W-1:0] mask_bit,
    input  logic [NUM_BANKS-1:0]        rd_bank_stb,
    output logic                        int_pull_low
);
    localparam int LINES      = NUM_BANKS * BANK_W;
    localparam int SETTLE_LEN = SYNC_STAGES + 1;

    logic [LINES-1:0]     pin_sync;
    logic [NUM_BANKS-1:0] pend_bank;
    logic                 settling;
    logic                 flagged;

    irq_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_async),
        .q_sync  (pin_sync)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            irq_bank #(.BANK_W(BANK_W)) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .sync_b (pin_sync[b*BANK_W +: BANK_W]),
                .cfg_b  (cfg_is_input[b*BANK_W +: BANK_W]),
                .mask_b (mask_bit[b*BANK_W +: BANK_W]),
                .load   (settling | rd_bank_stb[b]),
                .pend   (pend_bank[b])
            );
        end
    endgenerate

    irq_seq #(.SETTLE_LEN(SETTLE_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_any (|pend_bank),
        .settling (settling),
        .flagged  (flagged)
    );

    assign int_pull_low = flagged;

    // R6: the interrupt stays asserted while any bank is pending
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!settling && pend_bank != '0) |=> int_pull_low);

    // R1: the output is released throughout the settle period
    p_settle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        settling |-> !int_pull_low);
endmodule

// File: tb/tb_irq_change_detect.sv
module tb_irq_change_detect;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [39:0] pin_async = 40'h00_A5_00_3C_01;
    logic [39:0] cfg_is_input = '1;
    logic [39:0] mask_bit = '0;
    logic [4:0]  rd_bank_stb = '0;
    logic        int_pull_low;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_change_detect dut (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
        .cfg_is_input(cfg_is_input), .mask_bit(mask_bit),
        .rd_bank_stb(rd_bank_stb), .int_pull_low(int_pull_low)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        n_chk++;
        if (int_pull_low !== exp) begin
            n_fail++;
            $display("FAIL %s: int_pull_low=%b expected=%b", req, int_pull_low, exp);
        end
    endtask

    task automatic rd(input int b);
        rd_bank_stb[b] = 1'b1;
        step(1);
        rd_bank_stb = '0;
        step(2);
    endtask

    task automatic t_reset;
        step(3);
        check("R1 during reset", 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1);
            check("R1 settle", 1'b0);
        end
        step(4);
        check("R9 stable pins after settle", 1'b0);
    endtask

    task automatic t_change;
        pin_async[3] = ~pin_async[3];
        step(2);
        check("R2 latency not yet", 1'b0);
        step(1);
        check("R2 asserted", 1'b1);
        rd(0);
        check("R5 read clears", 1'b0);
    endtask

    task automatic t_mask;
        mask_bit[12] = 1'b1;
        pin_async[12] = ~pin_async[12];
        step(4);
        check("R3 masked change", 1'b0);
        mask_bit[12] = 1'b0;
        step(1);
        check("R8 unmask asserts", 1'b1);
        mask_bit[12] = 1'b1;
        step(1);
        check("R8 mask releases", 1'b0);
        rd(1);
        mask_bit[12] = 1'b0;
        step(2);
        check("R5 resynced bank", 1'b0);
    endtask

    task automatic t_outcfg;
        cfg_is_input[20] = 1'b0;
        pin_async[20] = ~pin_async[20];
        step(4);
        check("R4 output line", 1'b0);
        cfg_is_input[20] = 1'b1;
        step(1);
        check("R8 config to input asserts", 1'b1);
        rd(2);
        check("R5 bank2 read", 1'b0);
    endtask

    task automatic t_other_bank;
        pin_async[33] = ~pin_async[33];
        step(3);
        check("R2 bank4", 1'b1);
        rd(0);
        check("R6 other bank read", 1'b1);
        rd(4);
        check("R5 own bank read", 1'b0);
    endtask

    task automatic t_return;
        pin_async[39] = ~pin_async[39];
        step(3);
        check("R7 pending", 1'b1);
        pin_async[39] = ~pin_async[39];
        step(3);
        check("R7 returned", 1'b0);
    endtask

    task automatic t_multi;
        pin_async[9]  = ~pin_async[9];
        pin_async[27] = ~pin_async[27];
        step(3);
        check("R2 two banks", 1'b1);
        rd(1);
        check("R6 bank3 still pending", 1'b1);
        rd(3);
        check("R5 all read", 1'b0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset;
        t_change;
        t_mask;
        t_outcfg;
        t_other_bank;
        t_return;
        t_multi;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule